// File: doc/BRIEF.md
# Bidirectional Shift/Storage Register with Shared Parallel Pins

This block is an eight-bit storage register. On each rising clock edge it does one of five things: clear, hold, shift toward the most significant bit, shift toward the least significant bit, or load a parallel word. A two-bit mode input selects the operation. An active-low clear input overrides the mode and zeroes the register at the next edge.

The parallel data pins are shared between input and output. They are modelled as three separate signals: a pad input word, a pad output word and a per-pin drive enable. The pad cell and the surrounding pin logic combine these at chip level. The drivers are on only when both active-low output enables are low. They switch off on their own whenever the load mode is selected, so that an external source can drive the pins without contention.

The lowest and the highest register bits are always present on two dedicated serial outputs, whatever the driver state. Several registers can therefore be chained into longer words. To chain two registers, connect the high serial output of the lower register to the upward serial input of the upper register, and connect the low serial output of the upper register to the downward serial input of the lower register.

Top module: `bishift_reg`

## Requirements
- R1: When `clr_n` is 0 at a rising clock edge, every register bit becomes 0. This holds whatever the value of `mode`.
- R2: With `clr_n` = 1 and `mode` = 2'b00 (hold), the register keeps its value across the edge.
- R3: With `clr_n` = 1 and `mode` = 2'b01 (shift up), bit i takes the old bit i-1 for i from 1 to 7, and bit 0 takes `ser_in_lo`.
- R4: With `clr_n` = 1 and `mode` = 2'b10 (shift down), bit i takes the old bit i+1 for i from 0 to 6, and bit 7 takes `ser_in_hi`.
- R5: With `clr_n` = 1 and `mode` = 2'b11 (load), the register takes the value of `pad_in`.
- R6: `pad_oe` is all ones when `oe_a_n` = 0, `oe_b_n` = 0 and `mode` is not 2'b11. In every other case it is all zeros. It is never a mix of ones and zeros.
- R7: `pad_out` always carries the current register value, so a driven pin shows its stored bit.
- R8: `ser_out_lo` equals register bit 0 and `ser_out_hi` equals register bit 7 at all times, whether the drivers are on or off.
- R9: Clear, shift, load and hold update the register normally while the drivers are switched off by either output enable.
- R10: Two instances chained through their serial pins behave as one 16-bit register, for shifts in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low; overrides the mode |
| mode | input | 2 | Operation: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_in_lo | input | 1 | Serial bit that enters bit 0 when shifting up |
| ser_in_hi | input | 1 | Serial bit that enters bit 7 when shifting down |
| oe_a_n | input | 1 | First pin-driver enable, active low |
| oe_b_n | input | 1 | Second pin-driver enable, active low |
| pad_in | input | 8 | Value seen on the shared pins; captured in load mode |
| pad_out | output | 8 | Value the block drives onto the shared pins |
| pad_oe | output | 8 | Per-pin driver enable, high when the block drives the pin |
| ser_out_lo | output | 1 | Register bit 0, used for chaining |
| ser_out_hi | output | 1 | Register bit 7, used for chaining |

## Verification
A wrong register value reaches `pad_out` and both serial outputs in the cycle after the faulty edge. If the wrong value lands in an interior bit, the serial outputs show it only after enough shifts to carry that bit to an end. The pins still reveal it at once, as long as the drivers are on. A wrong enable decode is combinational, so it shows on `pad_oe` in the same cycle that the modes or enables change. A driver left on during load mode would collide with the bench's model of the external driver at once. A fault in the serial linkage shows in the chained pair's 16-bit word one shift after the bit crosses the boundary between the two registers.

// File: rtl/bishift_pkg.sv
package bishift_pkg;

    // Operation codes; the numeric values are the external mode encoding.
    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_UP   = 2'b01,
        OP_DOWN = 2'b10,
        OP_LOAD = 2'b11
    } op_e;

endpackage

// File: rtl/bishift_decode.sv
module bishift_decode
    import bishift_pkg::*;
(
    input  logic       clr_n,
    input  logic [1:0] mode,
    output logic       do_clear,
    output op_e        op
);

    always_comb begin
        do_clear = ~clr_n;
        op       = op_e'(mode);
    end

endmodule

// File: rtl/bishift_next.sv
module bishift_next
    import bishift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             do_clear,
    input  op_e              op,
    input  logic [WIDTH-1:0] cur,
    input  logic             ser_lo,
    input  logic             ser_hi,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] up_val;
    logic [WIDTH-1:0] down_val;

    // Per-bit neighbour selection for both shift directions.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            if (i == 0) begin : g_lo
                assign up_val[i] = ser_lo;
            end else begin : g_lo_mid
                assign up_val[i] = cur[i-1];
            end
            if (i == TOP) begin : g_hi
                assign down_val[i] = ser_hi;
            end else begin : g_hi_mid
                assign down_val[i] = cur[i+1];
            end
        end
    endgenerate

    always_comb begin
        if (do_clear) begin
            nxt = '0;
        end else begin
            unique case (op)
                OP_HOLD: nxt = cur;
                OP_UP:   nxt = up_val;
                OP_DOWN: nxt = down_val;
                OP_LOAD: nxt = load_val;
                default: nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/bishift_drive.sv
module bishift_drive
    import bishift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  op_e              op,
    output logic [WIDTH-1:0] pin_en
);

    logic drive_on;

    always_comb begin
        drive_on = ~oe_a_n & ~oe_b_n & (op != OP_LOAD);
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_en
            assign pin_en[i] = drive_on;
        end
    endgenerate

endmodule

// File: rtl/bishift_reg.sv
module bishift_reg
    import bishift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             ser_in_lo,
    input  logic             ser_in_hi,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic             ser_out_lo,
    output logic             ser_out_hi
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } store_t;

    store_t           st_d;
    store_t           st_q;
    logic             do_clear;
    op_e              op;
    logic [WIDTH-1:0] nxt_bits;

    bishift_decode u_dec (
        .clr_n    (clr_n),
        .mode     (mode),
        .do_clear (do_clear),
        .op       (op)
    );

    bishift_next #(.WIDTH(WIDTH)) u_nxt (
        .do_clear (do_clear),
        .op       (op),
        .cur      (st_q.bits),
        .ser_lo   (ser_in_lo),
        .ser_hi   (ser_in_hi),
        .load_val (pad_in),
        .nxt      (nxt_bits)
    );

    bishift_drive #(.WIDTH(WIDTH)) u_drv (
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .op     (op),
        .pin_en (pad_oe)
    );

    always_comb begin
        st_d      = st_q;
        st_d.bits = nxt_bits;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        pad_out    = st_q.bits;
        ser_out_lo = st_q.bits[0];
        ser_out_hi = st_q.bits[TOP];
    end

endmodule

// File: rtl/bishift_reg_chk.sv
module bishift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic [1:0]       mode,
    input logic             ser_in_lo,
    input logic             ser_in_hi,
    input logic             oe_a_n,
    input logic             oe_b_n,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic             ser_out_lo,
    input logic             ser_out_hi
);

    // Becomes 1 at the first edge that sees a clear; the register is known from then on.
    logic live_q = 1'b0;

    always_ff @(posedge clk) begin
        live_q <= live_q | ~clr_n;
    end

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!live_q)
        !clr_n |=> pad_out == '0);

    // R2
    hold_keep_chk: assert property (@(posedge clk) disable iff (!live_q)
        (clr_n && mode == 2'b00) |=> $stable(pad_out));

    // R3
    shift_up_chk: assert property (@(posedge clk) disable iff (!live_q)
        (clr_n && mode == 2'b01) |=>
            pad_out == {$past(pad_out[WIDTH-2:0]), $past(ser_in_lo)});

    // R4
    shift_down_chk: assert property (@(posedge clk) disable iff (!live_q)
        (clr_n && mode == 2'b10) |=>
            pad_out == {$past(ser_in_hi), $past(pad_out[WIDTH-1:1])});

    // R5
    load_take_chk: assert property (@(posedge clk) disable iff (!live_q)
        (clr_n && mode == 2'b11) |=> pad_out == $past(pad_in));

    // R6
    oe_off_load_chk: assert property (@(posedge clk) disable iff (!live_q)
        mode == 2'b11 |-> pad_oe == '0);

    // R6
    oe_off_enable_chk: assert property (@(posedge clk) disable iff (!live_q)
        (oe_a_n || oe_b_n) |-> pad_oe == '0);

    // R6
    oe_uniform_chk: assert property (@(posedge clk) disable iff (!live_q)
        (pad_oe == '0) || (pad_oe == '1));

    // R8
    ser_ends_chk: assert property (@(posedge clk) disable iff (!live_q)
        ser_out_lo == pad_out[0] && ser_out_hi == pad_out[WIDTH-1]);

endmodule

bind bishift_reg bishift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .clr_n      (clr_n),
    .mode       (mode),
    .ser_in_lo  (ser_in_lo),
    .ser_in_hi  (ser_in_hi),
    .oe_a_n     (oe_a_n),
    .oe_b_n     (oe_b_n),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .ser_out_lo (ser_out_lo),
    .ser_out_hi (ser_out_hi)
);

// File: tb/tb_bishift_reg.sv
module tb_bishift_reg;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Single device under test
    logic         clr_n = 1'b1;
    logic [1:0]   mode = 2'b00;
    logic         s_lo = 1'b0, s_hi = 1'b0, oa = 1'b1, ob = 1'b1;
    logic [W-1:0] pin = '0;
    logic [W-1:0] p_out, p_oe;
    logic         so_lo, so_hi;
    logic [W-1:0] exp_q;

    bishift_reg #(.WIDTH(W)) dut (
        .clk(clk), .clr_n(clr_n), .mode(mode), .ser_in_lo(s_lo), .ser_in_hi(s_hi),
        .oe_a_n(oa), .oe_b_n(ob), .pad_in(pin), .pad_out(p_out), .pad_oe(p_oe),
        .ser_out_lo(so_lo), .ser_out_hi(so_hi)
    );

    // Chained pair forming a 16-bit register
    logic         c_clr_n = 1'b1;
    logic [1:0]   c_mode = 2'b00;
    logic         c_in_lo = 1'b0, c_in_hi = 1'b0;
    logic [W-1:0] c_pin_lo = '0, c_pin_hi = '0;
    logic [W-1:0] c_out_lo, c_out_hi, c_oe_lo, c_oe_hi;
    logic         lo_top, hi_bot, lo_bot, hi_top;
    logic [2*W-1:0] exp_c;

    bishift_reg #(.WIDTH(W)) casc_lo (
        .clk(clk), .clr_n(c_clr_n), .mode(c_mode), .ser_in_lo(c_in_lo), .ser_in_hi(hi_bot),
        .oe_a_n(1'b0), .oe_b_n(1'b0), .pad_in(c_pin_lo), .pad_out(c_out_lo), .pad_oe(c_oe_lo),
        .ser_out_lo(lo_bot), .ser_out_hi(lo_top)
    );

    bishift_reg #(.WIDTH(W)) casc_hi (
        .clk(clk), .clr_n(c_clr_n), .mode(c_mode), .ser_in_lo(lo_top), .ser_in_hi(c_in_hi),
        .oe_a_n(1'b0), .oe_b_n(1'b0), .pad_in(c_pin_hi), .pad_out(c_out_hi), .pad_oe(c_oe_hi),
        .ser_out_lo(hi_bot), .ser_out_hi(hi_top)
    );

    function automatic logic [W-1:0] model_next(input logic [W-1:0] cur, input logic c,
            input logic [1:0] m, input logic lo, input logic hi, input logic [W-1:0] d);
        if (!c) return '0;
        case (m)
            2'b01:   return {cur[W-2:0], lo};
            2'b10:   return {hi, cur[W-1:1]};
            2'b11:   return d;
            default: return cur;
        endcase
    endfunction

    function automatic logic [W-1:0] model_oe(input logic a, input logic b, input logic [1:0] m);
        return (!a && !b && m != 2'b11) ? '1 : '0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    // Called at a falling edge: drive, check enables, clock once, check state.
    task automatic step(input string tag, input logic c, input logic [1:0] m, input logic lo,
            input logic hi, input logic a, input logic b, input logic [W-1:0] d);
        logic ext_drive;
        clr_n = c; mode = m; s_lo = lo; s_hi = hi; oa = a; ob = b; pin = d;
        #1;
        chk({"R6 oe ", tag}, 32'(p_oe), 32'(model_oe(a, b, m)));
        // The external source drives the pins only in load mode; the block must be off then.
        ext_drive = (m == 2'b11);
        if (ext_drive) chk({"R6 contention ", tag}, 32'(p_oe), 32'h0);
        exp_q = model_next(exp_q, c, m, lo, hi, d);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R7 pad_out"}, 32'(p_out), 32'(exp_q));
        chk({"R8 serial ends ", tag}, {30'd0, so_hi, so_lo}, {30'd0, exp_q[W-1], exp_q[0]});
    endtask

    task automatic cstep(input string tag, input logic c, input logic [1:0] m, input logic lo,
            input logic hi, input logic [2*W-1:0] d);
        c_clr_n = c; c_mode = m; c_in_lo = lo; c_in_hi = hi;
        c_pin_lo = d[W-1:0]; c_pin_hi = d[2*W-1:W];
        if (!c) exp_c = '0;
        else case (m)
            2'b01: exp_c = {exp_c[2*W-2:0], lo};
            2'b10: exp_c = {hi, exp_c[2*W-1:1]};
            2'b11: exp_c = d;
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        chk({"R10 chain ", tag}, 32'({c_out_hi, c_out_lo}), 32'(exp_c));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h5EED_0423));
        exp_q = '0;
        exp_c = '0;
        @(negedge clk);

        // R1: clear from unknown state, in load mode with drivers enabled
        step("R1 clear", 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF);
        // R5: load with drivers requested on: they must stay off
        step("R5 load", 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
        // R2: hold keeps value, drivers on
        step("R2 hold", 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R6 drivers on in hold", 32'(p_oe), 32'hFF);
        // R3: shift up, 1 entering bit 0 -> 0x4B
        step("R3 up", 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R3 up value", 32'(p_out), 32'h4B);
        // R4: shift down, 0 entering bit 7 -> 0x25
        step("R4 down", 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R4 down value", 32'(p_out), 32'h25);
        // R9: drivers off by each enable, register keeps working
        step("R9 up oeA off", 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
        step("R9 down oeB off", 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
        step("R9 load both off", 1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8'h81);
        chk("R9 load while off", 32'(p_out), 32'h81);
        step("R9 hold reveal", 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R9 drivers back on", 32'(p_oe), 32'hFF);
        // R1: clear overrides shift
        step("R1 clear over shift", 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF);

        // Constrained random mix: clear rare, all modes and enables
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step("rand", (r[3:0] != 4'd0), r[5:4], r[6], r[7], r[8] & r[9], r[10] & r[11], r[19:12]);
        end

        // R10: chained pair
        cstep("clear", 1'b0, 2'b00, 1'b0, 1'b0, 16'h0000);
        cstep("load", 1'b1, 2'b11, 1'b0, 1'b0, 16'h3C81);
        for (int i = 0; i < 20; i++) cstep("up", 1'b1, 2'b01, i[0] ^ i[2], 1'b0, 16'h0);
        cstep("reload", 1'b1, 2'b11, 1'b0, 1'b0, 16'hC35A);
        for (int i = 0; i < 20; i++) cstep("down", 1'b1, 2'b10, 1'b0, i[1] | i[3], 16'h0);
        for (int i = 0; i < 200; i++) begin
            logic [31:0] r;
            r = $urandom;
            cstep("rand", (r[4:0] != 5'd0), r[6:5], r[7], r[8], r[31:16]);
        end

        finished = 1'b1;
        summary();
    end

endmodule